// File: doc/BRIEF.md
# Transmit-Empty Interrupt Timer

This block sits beside the transmit FIFO of a FIFO-mode UART and decides when the transmit-buffer-empty interrupt becomes pending. It watches the transmitter-empty level, the FIFO fill count, host writes to the transmit buffer and host reads of the interrupt identification register. It drives one pending interrupt line and a 4-bit identification code.

When the transmitter goes empty, the interrupt is normally raised at once. There is one exception. If the FIFO never held two or more bytes at the same time since the previous empty event, the interrupt is held back by one character time less the final stop bit. That delay is counted in bit-rate ticks and sized from the configured data length, parity and stop bits. The first empty event after FIFO mode is switched on is never delayed.

The serial shifter and the FIFO storage live outside this block.

Top module: `txe_irq_timer`

## Requirements
- R1: After reset `irq_o` is 0 and `iir_code_o` is 4'h1 (nothing pending). While an interrupt is pending, `iir_code_o` is 4'h2.
- R2: Suppose `fifo_cnt_i` reached 2 or more at any point since the last rising edge of `thre_i`. Then the next rising edge of `thre_i` sets `irq_o` one clock later.
- R3: If no such occupancy was seen, the rising edge of `thre_i` starts a delay of D+P+S bit ticks. D is data bits (5 + `data_bits_i`, for codes 0..3). P is 1 when `parity_en_i` is set. S is 2 when `two_stop_i` is set, else 1. `irq_o` rises in the cycle after the tick that completes the delay (8N1: 9 ticks, 5N1: 6, 6-bit with parity and 1 stop: 8, 8E2: 11).
- R4: The first empty event after a `fifo_en_rise_i` pulse is raised without delay. This includes the case where `thre_i` is already high during the pulse.
- R5: A `thr_wr_i` pulse clears a pending interrupt one clock later.
- R6: An `iir_rd_i` pulse clears a pending interrupt. It is not raised again until the buffer is written and `thre_i` rises again.
- R7: A `thr_wr_i` pulse while a delay is running cancels it, and no interrupt follows from that delay.
- R8: With `fifo_en_i` or `tx_ie_i` low, no interrupt is raised. Dropping either one clears a pending interrupt one clock later.
- R9: The occupancy record is cleared on each rising edge of `thre_i`, so a later single-byte cycle is delayed again.
- R10: A write in the same cycle as the completing tick leaves no interrupt. An identification read in the same cycle as the completing tick leaves the interrupt pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFO mode enable level |
| fifo_en_rise_i | input | 1 | One-cycle pulse when FIFO mode is switched on |
| tx_ie_i | input | 1 | Transmit-empty interrupt enable |
| data_bits_i | input | 2 | Data length code, 5 + code bits |
| parity_en_i | input | 1 | Parity bit present |
| two_stop_i | input | 1 | Two stop bits |
| baud_tick_i | input | 1 | One pulse per serial bit time |
| thr_wr_i | input | 1 | Host write to transmit buffer |
| iir_rd_i | input | 1 | Host read of interrupt identification |
| fifo_cnt_i | input | CNT_W | Transmit FIFO fill count |
| thre_i | input | 1 | Transmitter-empty indication |
| irq_o | output | 1 | Transmit-empty interrupt pending |
| iir_code_o | output | 4 | Identification code, 4'h2 pending, 4'h1 none |

## Verification
The delay counter can finish in the same clock in which the host acts on the interrupt path. A write may coincide with the completing tick, and so may an identification read, and these two cases settle in opposite ways. The bench runs a delay down to one tick short of its end, then drives the last tick together with either `thr_wr_i` or `iir_rd_i` in a single cycle. After that edge it checks that `irq_o` stays low for the write and high for the read, and that a separate read afterwards clears it.

// File: rtl/txe_pkg.sv
package txe_pkg;
  localparam int MIN_DATA   = 5;
  localparam int MAX_DELAY  = 8 + 1 + 2;
  localparam int TMR_W      = $clog2(MAX_DELAY + 1);
  localparam int MULTI_LVL  = 2;

  typedef enum logic [3:0] {
    IIR_NONE      = 4'h1,
    IIR_THR_EMPTY = 4'h2
  } iir_code_e;

  // character time less the final stop bit: data + parity + stops
  function automatic logic [TMR_W-1:0] char_delay(input logic [1:0] wl,
                                                   input logic par,
                                                   input logic two);
    return TMR_W'(MIN_DATA) + TMR_W'(wl) + TMR_W'(par) + TMR_W'(1) + TMR_W'(two);
  endfunction
endpackage

// File: rtl/txe_occupancy.sv
module txe_occupancy
  import txe_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gate_i,
  input  logic             fifo_en_rise_i,
  input  logic             thre_i,
  input  logic [CNT_W-1:0] fifo_cnt_i,
  output logic             empty_ev_o,
  output logic             immediate_o
);
  logic thre_q, multi_q, armed_q;
  logic thre_rise, multi_now;

  assign thre_rise   = thre_i & ~thre_q;
  assign multi_now   = fifo_cnt_i >= CNT_W'(MULTI_LVL);
  assign empty_ev_o  = gate_i & (thre_rise | (fifo_en_rise_i & thre_i));
  assign immediate_o = armed_q | fifo_en_rise_i | multi_q | multi_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thre_q  <= 1'b0;
      multi_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      thre_q <= thre_i;
      if (thre_rise)      multi_q <= 1'b0;
      else if (multi_now) multi_q <= 1'b1;
      if (empty_ev_o)          armed_q <= 1'b0;
      else if (fifo_en_rise_i) armed_q <= 1'b1;
    end
  end

  assert_sticky_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (multi_now && !thre_rise) |=> multi_q);
  assert_sticky_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thre_rise |=> !multi_q);
  assert_first_used_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_ev_o |=> !armed_q);
endmodule

// File: rtl/txe_char_timer.sv
module txe_char_timer
  import txe_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TMR_W-1:0] load_i,
  input  logic             cancel_i,
  input  logic             tick_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [TMR_W-1:0] cnt_q;

  assign busy_o = cnt_q != '0;
  assign done_o = tick_i && cnt_q == TMR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (cancel_i)         cnt_q <= '0;
    else if (start_i)          cnt_q <= load_i;
    else if (tick_i && busy_o) cnt_q <= cnt_q - TMR_W'(1);
  end

  assert_cancel_stops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_i |=> !busy_o);
  assert_count_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> cnt_q <= TMR_W'(MAX_DELAY));
  assert_hold_no_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i && !cancel_i && !start_i) |=> $stable(cnt_q));
endmodule

// File: rtl/txe_irq_ctrl.sv
module txe_irq_ctrl
  import txe_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       gate_i,
  input  logic       set_now_i,
  input  logic       tmr_done_i,
  input  logic       thr_wr_i,
  input  logic       iir_rd_i,
  output logic       irq_o,
  output logic [3:0] iir_code_o
);
  logic pend_q, set;

  assign set        = set_now_i | tmr_done_i;
  assign irq_o      = pend_q;
  assign iir_code_o = pend_q ? IIR_THR_EMPTY : IIR_NONE;

  // write beats set; set beats read (the read saw the old state)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (!gate_i)  pend_q <= 1'b0;
    else if (thr_wr_i) pend_q <= 1'b0;
    else if (set)      pend_q <= 1'b1;
    else if (iir_rd_i) pend_q <= 1'b0;
  end

  assert_gate_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i |=> !pend_q);
  assert_write_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_i |=> !pend_q);
  assert_read_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd_i && !set_now_i && !tmr_done_i) |=> !pend_q);
  assert_rise_has_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(set_now_i || tmr_done_i));
endmodule

// File: rtl/txe_irq_timer.sv
module txe_irq_timer
  import txe_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             fifo_en_rise_i,
  input  logic             tx_ie_i,
  input  logic [1:0]       data_bits_i,
  input  logic             parity_en_i,
  input  logic             two_stop_i,
  input  logic             baud_tick_i,
  input  logic             thr_wr_i,
  input  logic             iir_rd_i,
  input  logic [CNT_W-1:0] fifo_cnt_i,
  input  logic             thre_i,
  output logic             irq_o,
  output logic [3:0]       iir_code_o
);
  logic gate, empty_ev, immediate, tmr_busy, tmr_done;

  assign gate = fifo_en_i & tx_ie_i;

  txe_occupancy #(.CNT_W(CNT_W)) u_occ (
    .clk_i, .rst_ni, .gate_i(gate), .fifo_en_rise_i, .thre_i, .fifo_cnt_i,
    .empty_ev_o(empty_ev), .immediate_o(immediate)
  );

  txe_char_timer u_tmr (
    .clk_i, .rst_ni,
    .start_i(empty_ev & ~immediate),
    .load_i(char_delay(data_bits_i, parity_en_i, two_stop_i)),
    .cancel_i(thr_wr_i | ~gate),
    .tick_i(baud_tick_i),
    .busy_o(tmr_busy), .done_o(tmr_done)
  );

  txe_irq_ctrl u_ctrl (
    .clk_i, .rst_ni, .gate_i(gate),
    .set_now_i(empty_ev & immediate), .tmr_done_i(tmr_done),
    .thr_wr_i, .iir_rd_i, .irq_o, .iir_code_o
  );

  assert_delay_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_busy && !tmr_done && !empty_ev && !irq_o) |=> !irq_o);
endmodule

// File: tb/txe_irq_timer_bench.sv
`timescale 1ns/1ps
module txe_irq_timer_bench;
  logic clk = 0, rst_ni = 0;
  logic fifo_en = 0, fifo_en_rise = 0, tx_ie = 0;
  logic [1:0] data_bits = 2'd3;
  logic parity_en = 0, two_stop = 0, baud_tick = 0, thr_wr = 0, iir_rd = 0;
  logic [4:0] fifo_cnt = 0;
  logic thre = 0;
  logic irq;
  logic [3:0] code;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  txe_irq_timer u_txe_irq_timer (
    .clk_i(clk), .rst_ni, .fifo_en_i(fifo_en), .fifo_en_rise_i(fifo_en_rise),
    .tx_ie_i(tx_ie), .data_bits_i(data_bits), .parity_en_i(parity_en),
    .two_stop_i(two_stop), .baud_tick_i(baud_tick), .thr_wr_i(thr_wr),
    .iir_rd_i(iir_rd), .fifo_cnt_i(fifo_cnt), .thre_i(thre),
    .irq_o(irq), .iir_code_o(code)
  );

  task automatic step(); @(posedge clk); #1; endtask

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      baud_tick = 1; step(); baud_tick = 0; step();
    end
  endtask

  task automatic host_write(int peak);
    thr_wr = 1; thre = 0; fifo_cnt = 5'(peak); step();
    thr_wr = 0; step();
    fifo_cnt = 0; step();
  endtask

  task automatic clear_read();
    iir_rd = 1; step(); iir_rd = 0; step();
  endtask

  task automatic t_reset();
    check("R1 reset irq", {3'b0, irq}, 4'h0);
    check("R1 reset code", code, 4'h1);
  endtask

  task automatic t_first_immediate();
    tx_ie = 1; thre = 1; fifo_en = 1; fifo_en_rise = 1; step(); fifo_en_rise = 0;
    check("R4 first after enable", {3'b0, irq}, 4'h1);
    check("R1 pending code", code, 4'h2);
  endtask

  task automatic t_read_clear();
    clear_read();
    check("R6 read clears", {3'b0, irq}, 4'h0);
    ticks(12);
    check("R6 no re-raise", {3'b0, irq}, 4'h0);
  endtask

  task automatic t_delay(logic [1:0] wl, logic p, logic s2, int len, string req);
    data_bits = wl; parity_en = p; two_stop = s2;
    host_write(1);
    thre = 1; step();
    check({req, " held at edge"}, {3'b0, irq}, 4'h0);
    ticks(len - 1);
    check({req, " held before end"}, {3'b0, irq}, 4'h0);
    ticks(1);
    check({req, " raised at end"}, {3'b0, irq}, 4'h1);
    clear_read();
  endtask

  task automatic t_multi();
    data_bits = 3; parity_en = 0; two_stop = 0;
    host_write(3);
    thre = 1; step();
    check("R2 immediate after multi", {3'b0, irq}, 4'h1);
    host_write(3);
    check("R5 write clears", {3'b0, irq}, 4'h0);
    thre = 1; step();
    check("R2 immediate again", {3'b0, irq}, 4'h1);
    clear_read();
    host_write(1);
    thre = 1; step();
    check("R9 sticky cleared delay", {3'b0, irq}, 4'h0);
    ticks(9);
    check("R9 delayed raise", {3'b0, irq}, 4'h1);
    clear_read();
  endtask

  task automatic t_cancel();
    host_write(1);
    thre = 1; step();
    ticks(3);
    thr_wr = 1; thre = 0; step(); thr_wr = 0;
    ticks(12);
    check("R7 write cancels delay", {3'b0, irq}, 4'h0);
  endtask

  task automatic t_collide();
    host_write(1);
    thre = 1; step();
    ticks(8);
    baud_tick = 1; thr_wr = 1; thre = 0; step(); baud_tick = 0; thr_wr = 0;
    check("R10 write with expiry", {3'b0, irq}, 4'h0);
    step();
    check("R10 write with expiry later", {3'b0, irq}, 4'h0);
    host_write(1);
    thre = 1; step();
    ticks(8);
    baud_tick = 1; iir_rd = 1; step(); baud_tick = 0; iir_rd = 0;
    check("R10 read with expiry", {3'b0, irq}, 4'h1);
    clear_read();
    check("R10 later read clears", {3'b0, irq}, 4'h0);
  endtask

  task automatic t_gating();
    tx_ie = 0;
    host_write(3);
    thre = 1; step();
    check("R8 ie low no irq", {3'b0, irq}, 4'h0);
    ticks(12);
    tx_ie = 1; step();
    check("R8 ie low stays quiet", {3'b0, irq}, 4'h0);
    host_write(3);
    thre = 1; step();
    check("R8 pending before disable", {3'b0, irq}, 4'h1);
    fifo_en = 0; step();
    check("R8 disable clears", {3'b0, irq}, 4'h0);
    fifo_en = 1; fifo_en_rise = 1; step(); fifo_en_rise = 0;
    check("R4 re-enable immediate", {3'b0, irq}, 4'h1);
    clear_read();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rst_ni = 1; step();
    t_reset();
    t_first_immediate();
    t_read_clear();
    t_delay(2'd3, 1'b0, 1'b0, 9, "R3 8N1");
    t_delay(2'd0, 1'b0, 1'b0, 6, "R3 5N1");
    t_delay(2'd1, 1'b1, 1'b0, 8, "R3 6P1");
    t_delay(2'd3, 1'b1, 1'b1, 11, "R3 8E2");
    t_multi();
    t_cancel();
    t_collide();
    t_gating();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end
endmodule